// File: doc/BRIEF.md
# Hardware Mutex Register File

This block keeps a bank of lock entries that several tasks share. Each entry holds a lock flag and the identifier of the task that took it. A single command port carries the requesting task's identifier, an entry address and an opcode. The port offers three operations. The first is an atomic test-and-set, which claims a free entry for the requester. The second is a release, which frees an entry and may be issued by any task. The third is a plain read, which leaves the entry untouched. Every command returns the entry as it stood before the command, one cycle later.

Each task has its own enable mask with one bit per entry. When an entry goes from locked to free, every task whose mask selects that entry receives a one-cycle wake-up pulse. A scheduler can use this pulse to resume a task that is waiting for the lock.

Each entry is a two-state machine. In state FREE, the SEIZE transition is taken on a test-and-set and moves the entry to HELD. In state HELD, the RELEASE transition is taken on a clear and moves the entry back to FREE. Every other command keeps the entry in its current state.

Top module: `mutex_bank`

## Requirements
- R1: Every command accepted with `cmd_valid` high produces `rsp_valid` high in the next cycle. At the same time `rsp_data` shows the addressed entry as it was before the command: the lock flag in the most significant bit and the owner identifier in the bits below it.
- R2: A test-and-set (opcode 1) leaves the addressed entry locked.
- R3: A test-and-set on a free entry writes the requester's identifier into the owner field.
- R4: A test-and-set on a locked entry changes neither the lock flag nor the owner. The response then names the current holder.
- R5: A clear (opcode 2) from any task leaves the entry free. The owner field keeps its last value.
- R6: A read (opcode 0, and the reserved opcode 3, which behaves the same) changes no entry.
- R7: In the cycle after a clear of a locked entry, `mutex_ev` bit t is high for exactly one cycle if bit a of task t's mask is set, where a is the cleared entry's address. A clear of an entry that is already free produces no pulse.
- R8: After reset, every entry reads as zero, and `rsp_valid` and `mutex_ev` are low.
- R9: A mask write loads `mask_data` into the mask of task `mask_task`. The new mask governs releases that happen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 test-and-set, 2 clear, 3 read |
| cmd_task | input | TASK_W | Requesting task identifier |
| cmd_addr | input | ADDR_W | Entry address |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | TASK_W+1 | Entry contents before the command |
| mask_we | input | 1 | Mask write strobe |
| mask_task | input | TASK_W | Task whose mask is written |
| mask_data | input | NUM_MUTEX | New enable mask |
| mutex_ev | output | NUM_TASKS | Per-task release pulse |

## Verification
The bench builds the block with five tasks and six entries. Five tasks is not a power of two, so the identifier field is three bits wide and the highest identifier, 4, exercises the full field. With six entries, two masks can overlap on one entry, so a single release has to wake two tasks at once. These values also let the bench check that a release wakes only the tasks whose mask selects the freed entry.

// File: rtl/mutex_bank_pkg.sv
package mutex_bank_pkg;
    typedef enum logic [1:0] {
        MOP_READ = 2'd0,
        MOP_TAS  = 2'd1,
        MOP_CLR  = 2'd2,
        MOP_PEEK = 2'd3
    } mop_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_st_e;
endpackage

// File: rtl/mutex_slot.sv
module mutex_slot
    import mutex_bank_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  mop_e            op,
    input  logic [ID_W-1:0] req_id,
    output logic            lock,
    output logic [ID_W-1:0] owner,
    output logic            release_o
);
    slot_st_e state_q, state_d;
    logic [ID_W-1:0] owner_q;
    logic seize;

    always_comb begin
        state_d   = state_q;
        seize     = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            SLOT_FREE: begin
                if (sel && op == MOP_TAS) begin
                    state_d = SLOT_HELD;
                    seize   = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (sel && op == MOP_CLR) begin
                    state_d   = SLOT_FREE;
                    release_o = 1'b1;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (seize) owner_q <= req_id;
        end
    end

    assign lock  = (state_q == SLOT_HELD);
    assign owner = owner_q;

    AST_TAS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == MOP_TAS) |=> lock); // R2
    AST_TAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == MOP_TAS && !lock) |=> (owner == $past(req_id))); // R3
    AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == MOP_TAS && lock) |=> ($stable(owner) && lock)); // R4
    AST_CLR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == MOP_CLR) |=> (!lock && $stable(owner))); // R5
    AST_READ_NOCHG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (op == MOP_READ || op == MOP_PEEK)) |=> ($stable(lock) && $stable(owner))); // R6
endmodule

// File: rtl/mutex_notify.sv
module mutex_notify #(
    parameter int NUM_TASKS = 8,
    parameter int NUM_MUTEX = 16,
    parameter int TASK_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [TASK_W-1:0]    mask_task,
    input  logic [NUM_MUTEX-1:0] mask_data,
    input  logic [NUM_MUTEX-1:0] rel_vec,
    output logic [NUM_TASKS-1:0] ev
);
    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
        logic [NUM_MUTEX-1:0] mask_q;
        logic ev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
                ev_q   <= 1'b0;
            end else begin
                if (mask_we && mask_task == TASK_W'(t)) mask_q <= mask_data;
                ev_q <= |(rel_vec & mask_q);
            end
        end

        assign ev[t] = ev_q;

        AST_EV_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
            ev_q |-> $past(|rel_vec)); // R7
    end
endmodule

// File: rtl/mutex_bank.sv
module mutex_bank
    import mutex_bank_pkg::*;
#(
    parameter int NUM_TASKS = 8,
    parameter int NUM_MUTEX = 16,
    localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
    localparam int ADDR_W = (NUM_MUTEX > 1) ? $clog2(NUM_MUTEX) : 1,
    localparam int ENT_W  = TASK_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [TASK_W-1:0]    cmd_task,
    input  logic [ADDR_W-1:0]    cmd_addr,
    output logic                 rsp_valid,
    output logic [ENT_W-1:0]     rsp_data,
    input  logic                 mask_we,
    input  logic [TASK_W-1:0]    mask_task,
    input  logic [NUM_MUTEX-1:0] mask_data,
    output logic [NUM_TASKS-1:0] mutex_ev
);
    mop_e op;
    logic [NUM_MUTEX-1:0] lock_vec;
    logic [NUM_MUTEX-1:0] rel_vec;
    logic [TASK_W-1:0]    owner_arr [NUM_MUTEX];
    logic [ENT_W-1:0]     old_ent;
    logic                 rsp_valid_q;
    logic [ENT_W-1:0]     rsp_data_q;

    assign op = mop_e'(cmd_op);

    for (genvar i = 0; i < NUM_MUTEX; i++) begin : g_slot
        logic sel_i;
        assign sel_i = cmd_valid && (cmd_addr == ADDR_W'(i));
        mutex_slot #(.ID_W(TASK_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel_i),
            .op        (op),
            .req_id    (cmd_task),
            .lock      (lock_vec[i]),
            .owner     (owner_arr[i]),
            .release_o (rel_vec[i])
        );
    end

    always_comb begin
        old_ent = '0;
        for (int i = 0; i < NUM_MUTEX; i++) begin
            if (cmd_addr == ADDR_W'(i)) old_ent = {lock_vec[i], owner_arr[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= cmd_valid;
            if (cmd_valid) rsp_data_q <= old_ent;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    mutex_notify #(
        .NUM_TASKS (NUM_TASKS),
        .NUM_MUTEX (NUM_MUTEX),
        .TASK_W    (TASK_W)
    ) u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_task (mask_task),
        .mask_data (mask_data),
        .rel_vec   (rel_vec),
        .ev        (mutex_ev)
    );

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid); // R1
    AST_RSP_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid)); // R1
    AST_EV_FROM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mutex_ev != '0) |-> $past(cmd_valid && cmd_op == 2'd2)); // R7
endmodule

// File: tb/tb_mutex_bank.sv
`timescale 1ns/1ps
module tb_mutex_bank;
    localparam int NT = 5;
    localparam int NM = 6;
    localparam int TW = 3;
    localparam int AW = 3;
    localparam int EW = TW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [TW-1:0] cmd_task = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic rsp_valid;
    logic [EW-1:0] rsp_data;
    logic mask_we = 1'b0;
    logic [TW-1:0] mask_task = '0;
    logic [NM-1:0] mask_data = '0;
    logic [NT-1:0] mutex_ev;

    always #2.5 clk = ~clk;

    mutex_bank #(.NUM_TASKS(NT), .NUM_MUTEX(NM)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_task(cmd_task), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mask_we(mask_we), .mask_task(mask_task),
        .mask_data(mask_data), .mutex_ev(mutex_ev)
    );

    int checks = 0;
    int errors = 0;
    bit monitor_on = 1'b0;
    bit done = 1'b0;

    logic          m_lock  [NM];
    logic [TW-1:0] m_owner [NM];
    logic [NM-1:0] m_mask  [NT];

    logic [EW-1:0] q_data [$];
    logic [NT-1:0] q_ev   [$];
    string         q_tag  [$];

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input int task_id, input int addr, input string tag);
        logic [NT-1:0] ev;
        @(negedge clk);
        ev = '0;
        q_data.push_back({m_lock[addr], m_owner[addr]});
        if (op == 2'd1) begin
            if (!m_lock[addr]) m_owner[addr] = TW'(task_id);
            m_lock[addr] = 1'b1;
        end else if (op == 2'd2) begin
            if (m_lock[addr])
                for (int t = 0; t < NT; t++) ev[t] = m_mask[t][addr];
            m_lock[addr] = 1'b0;
        end
        q_ev.push_back(ev);
        q_tag.push_back(tag);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_task  = TW'(task_id);
        cmd_addr  = AW'(addr);
        mask_we   = 1'b0;
    endtask

    task automatic set_mask(input int task_id, input logic [NM-1:0] m);
        @(negedge clk);
        cmd_valid = 1'b0;
        mask_we   = 1'b1;
        mask_task = TW'(task_id);
        mask_data = m;
        m_mask[task_id] = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            mask_we   = 1'b0;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (monitor_on) begin
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1 unexpected response got %h exp none", rsp_data);
                end else begin
                    string tg;
                    logic [EW-1:0] ed;
                    logic [NT-1:0] ee;
                    tg = q_tag.pop_front();
                    ed = q_data.pop_front();
                    ee = q_ev.pop_front();
                    check({tg, " R1 data"}, 8'(rsp_data), 8'(ed));
                    check({tg, " R7 event"}, 8'(mutex_ev), 8'(ee));
                end
            end else if (mutex_ev != '0) begin
                checks++;
                errors++;
                $display("FAIL R7 stray event got %h exp 00", mutex_ev);
            end
        end
    end

    initial begin
        for (int i = 0; i < NM; i++) begin
            m_lock[i] = 1'b0;
            m_owner[i] = '0;
        end
        for (int t = 0; t < NT; t++) m_mask[t] = '0;
        repeat (3) @(negedge clk);
        check("R8 rsp_valid at reset", 8'(rsp_valid), 8'h00);
        check("R8 mutex_ev at reset", 8'(mutex_ev), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1'b1;
        for (int a = 0; a < NM; a++) cmd(2'd0, 0, a, "R8 entry zero");
        set_mask(1, 6'b000001);
        set_mask(3, 6'b000011);
        cmd(2'd1, 2, 0, "R2 R3 tas free");
        cmd(2'd0, 0, 0, "R3 owner recorded");
        cmd(2'd1, 4, 0, "R4 tas held");
        cmd(2'd0, 1, 0, "R4 entry unchanged");
        cmd(2'd3, 3, 0, "R6 reserved read");
        cmd(2'd0, 3, 0, "R6 after reads");
        cmd(2'd2, 0, 0, "R5 R7 clear by other task");
        cmd(2'd0, 0, 0, "R5 owner kept");
        cmd(2'd2, 1, 0, "R7 clear of free entry");
        cmd(2'd1, 4, 1, "R3 tas top id");
        cmd(2'd2, 4, 1, "R7 single waiter");
        cmd(2'd1, 3, 5, "R2 tas last entry");
        set_mask(0, 6'b100000);
        cmd(2'd2, 1, 5, "R9 new mask used");
        cmd(2'd1, 1, 2, "R1 back to back first");
        cmd(2'd1, 0, 2, "R1 back to back second");
        cmd(2'd1, 4, 5, "R3 retake freed");
        cmd(2'd0, 2, 5, "R3 new owner");
        set_mask(0, 6'b000000);
        cmd(2'd2, 2, 5, "R9 mask cleared");
        cmd(2'd2, 3, 2, "R5 clear unmasked");
        cmd(2'd0, 0, 2, "R5 entry free");
        idle(4);
        check("R1 queue drained", 8'(q_data.size()), 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired got hang exp finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule